// File: doc/BRIEF.md
# Fractional Multiply Execution Unit

This unit executes the three fixed-point multiply instructions of a small 8-bit core. An issued 16-bit instruction word is decoded into a variant and two operand register numbers. The unit presents those register numbers on a register-file read port and takes the two operand bytes back in the same cycle. It then forms the 16-bit product, doubles it (one-bit left shift) so that the result reads as a fraction, and registers it for write-back into register pair 1:0. The carry and zero status flags are also updated.

The instruction retires one clock later. A small state machine records the outcome of each issue. `EXU_IDLE` means nothing is retiring. `EXU_WRITE` means a product is being written. `EXU_SKIP` means the multiplier feature is switched off, so the instruction retires as a no-op. The machine moves from any state to `EXU_WRITE` on an accepted issue with the feature on, to `EXU_SKIP` on an accepted issue with the feature off, and to `EXU_IDLE` otherwise. Instruction fetch, the other ALU operations and hazard handling belong to the surrounding core.

Top module: `fmul_unit`

## Requirements
- R1: An issue is accepted only when `instr_i[15:8]` is 8'h03 and {`instr_i[7]`,`instr_i[3]`} is 2'b01 (unsigned x unsigned), 2'b10 (signed x signed) or 2'b11 (signed x unsigned). Any other word causes no retire, no write and no flag update.
- R2: `src_a_idx_o` equals 16 + `instr_i[6:4]` and `src_b_idx_o` equals 16 + `instr_i[2:0]`, combinationally from `instr_i`. Only registers 16 to 23 are reachable.
- R3: In the unsigned x unsigned variant, both operands are zero-extended before the 16-bit multiply.
- R4: In the signed x signed variant, both operands are sign-extended before the multiply.
- R5: In the signed x unsigned variant, operand A is sign-extended and operand B is zero-extended.
- R6: The written result is the 16-bit product shifted left by one with a 0 shifted in. The low byte goes out on `pair_lo_o` (register 0) and the high byte on `pair_hi_o` (register 1), so bit 0 of `pair_lo_o` is 0 on every write.
- R7: `carry_o` takes bit 15 of the product as it was before the shift.
- R8: `zero_o` is 1 exactly when the 16-bit product before the shift is zero.
- R9: An accepted issue at a rising edge makes `retire_o` high for exactly the following cycle. On a write, the result and flags are valid with `pair_we_o` and `flag_we_o` in that same cycle.
- R10: With `mul_en_i` low, an accepted issue still pulses `retire_o`. It leaves `pair_we_o` and `flag_we_o` low, and `pair_lo_o`, `pair_hi_o`, `carry_o` and `zero_o` keep their previous values.
- R11: After reset, all outputs are 0 and the unit is in `EXU_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction word is presented this cycle |
| instr_i | input | 16 | Instruction word |
| mul_en_i | input | 1 | Multiplier feature present |
| src_a_idx_o | output | 5 | Register number of operand A |
| src_b_idx_o | output | 5 | Register number of operand B |
| src_a_data_i | input | 8 | Register file data for operand A |
| src_b_data_i | input | 8 | Register file data for operand B |
| retire_o | output | 1 | Instruction retires this cycle |
| pair_we_o | output | 1 | Write pair 1:0 this cycle |
| pair_lo_o | output | 8 | Byte for register 0 |
| pair_hi_o | output | 8 | Byte for register 1 |
| flag_we_o | output | 1 | Update carry and zero this cycle |
| carry_o | output | 1 | Carry flag value |
| zero_o | output | 1 | Zero flag value |

## Verification
The bench builds the unit with its default 8-bit operands, 5-bit register numbers and a bank base of 16. With these values, every operand register 16 to 23 and every sign combination of the three variants can be reached directly. The extreme operands 0x80 x 0x80 and 0xFF x 0xFF, together with zero, are driven in each variant, so the sign-extension rules, the carry taken before the shift, and the zero flag are each seen flipping. Random operands and register fields, a disabled feature, and non-matching opcode words (including the neighbouring 2'b00 variant code) complete the stimulus.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
    typedef enum logic [1:0] {
        FMV_NONE,
        FMV_UU,
        FMV_SS,
        FMV_SU
    } fmul_kind_t;

    typedef enum logic [1:0] {
        EXU_IDLE,
        EXU_WRITE,
        EXU_SKIP
    } exu_state_t;

    localparam logic [7:0] FMUL_MAJOR = 8'h03;
endpackage

// File: rtl/fmul_decode.sv
module fmul_decode
    import fmul_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int FIELD_W   = 3,
    parameter int BANK_BASE = 16
) (
    input  logic [15:0]      instr_i,
    output fmul_kind_t       kind_o,
    output logic [IDX_W-1:0] a_idx_o,
    output logic [IDX_W-1:0] b_idx_o
);
    localparam int DST_LSB = 4;
    localparam int SRC_LSB = 0;

    always_comb begin
        kind_o = FMV_NONE;
        if (instr_i[15:8] == FMUL_MAJOR) begin
            unique case ({instr_i[7], instr_i[3]})
                2'b01:   kind_o = FMV_UU;
                2'b10:   kind_o = FMV_SS;
                2'b11:   kind_o = FMV_SU;
                default: kind_o = FMV_NONE;
            endcase
        end
    end

    assign a_idx_o = IDX_W'(BANK_BASE) + IDX_W'(instr_i[DST_LSB +: FIELD_W]);
    assign b_idx_o = IDX_W'(BANK_BASE) + IDX_W'(instr_i[SRC_LSB +: FIELD_W]);
endmodule

// File: rtl/fmul_datapath.sv
module fmul_datapath
    import fmul_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fmul_kind_t            kind_i,
    input  logic [DATA_W-1:0]     op_a_i,
    input  logic [DATA_W-1:0]     op_b_i,
    output logic [2*DATA_W-1:0]   prod_shl_o,
    output logic                  carry_o,
    output logic                  zero_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic              a_sgn, b_sgn;
    logic [PROD_W-1:0] ext_a, ext_b, prod;

    always_comb begin
        unique case (kind_i)
            FMV_SS:  begin a_sgn = 1'b1; b_sgn = 1'b1; end
            FMV_SU:  begin a_sgn = 1'b1; b_sgn = 1'b0; end
            default: begin a_sgn = 1'b0; b_sgn = 1'b0; end
        endcase
    end

    assign ext_a = {{DATA_W{a_sgn & op_a_i[DATA_W-1]}}, op_a_i};
    assign ext_b = {{DATA_W{b_sgn & op_b_i[DATA_W-1]}}, op_b_i};
    assign prod  = ext_a * ext_b;

    assign carry_o    = prod[PROD_W-1];
    assign zero_o     = (prod == '0);
    assign prod_shl_o = {prod[PROD_W-2:0], 1'b0};
endmodule

// File: rtl/fmul_unit.sv
module fmul_unit
    import fmul_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 5,
    parameter int FIELD_W   = 3,
    parameter int BANK_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [15:0]       instr_i,
    input  logic              mul_en_i,
    output logic [IDX_W-1:0]  src_a_idx_o,
    output logic [IDX_W-1:0]  src_b_idx_o,
    input  logic [DATA_W-1:0] src_a_data_i,
    input  logic [DATA_W-1:0] src_b_data_i,
    output logic              retire_o,
    output logic              pair_we_o,
    output logic [DATA_W-1:0] pair_lo_o,
    output logic [DATA_W-1:0] pair_hi_o,
    output logic              flag_we_o,
    output logic              carry_o,
    output logic              zero_o
);
    localparam int PROD_W = 2 * DATA_W;

    fmul_kind_t        kind;
    logic [PROD_W-1:0] prod_shl;
    logic              c_next, z_next;
    exu_state_t        state_q, state_d;
    logic [PROD_W-1:0] res_q;
    logic              c_q, z_q;

    fmul_decode #(
        .IDX_W    (IDX_W),
        .FIELD_W  (FIELD_W),
        .BANK_BASE(BANK_BASE)
    ) u_dec (
        .instr_i(instr_i),
        .kind_o (kind),
        .a_idx_o(src_a_idx_o),
        .b_idx_o(src_b_idx_o)
    );

    fmul_datapath #(
        .DATA_W(DATA_W)
    ) u_dp (
        .kind_i    (kind),
        .op_a_i    (src_a_data_i),
        .op_b_i    (src_b_data_i),
        .prod_shl_o(prod_shl),
        .carry_o   (c_next),
        .zero_o    (z_next)
    );

    // Next state: every state reacts only to the current issue.
    always_comb begin
        state_d = EXU_IDLE;
        if (issue_i && kind != FMV_NONE) begin
            state_d = mul_en_i ? EXU_WRITE : EXU_SKIP;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXU_IDLE;
        else        state_q <= state_d;
    end

    // Result and flag registers, loaded only on a writing transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
        end else if (state_d == EXU_WRITE) begin
            res_q <= prod_shl;
            c_q   <= c_next;
            z_q   <= z_next;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        retire_o  = 1'b0;
        pair_we_o = 1'b0;
        unique case (state_q)
            EXU_WRITE: begin retire_o = 1'b1; pair_we_o = 1'b1; end
            EXU_SKIP:  retire_o = 1'b1;
            default:   ;
        endcase
    end

    assign flag_we_o = pair_we_o;
    assign pair_lo_o = res_q[DATA_W-1:0];
    assign pair_hi_o = res_q[PROD_W-1:DATA_W];
    assign carry_o   = c_q;
    assign zero_o    = z_q;
endmodule

// File: rtl/fmul_unit_chk.sv
module fmul_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic              mul_en_i,
    input logic              retire_o,
    input logic              pair_we_o,
    input logic [DATA_W-1:0] pair_lo_o,
    input logic [DATA_W-1:0] pair_hi_o,
    input logic              flag_we_o,
    input logic              carry_o,
    input logic              zero_o
);
    AST_WRITE_IMPLIES_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we_o |-> retire_o); // R9

    AST_RETIRE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |-> $past(issue_i)); // R9

    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !mul_en_i) |=> (!pair_we_o && !flag_we_o)); // R10

    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_we_o |-> ($stable(pair_lo_o) && $stable(pair_hi_o))); // R10

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_o |-> ($stable(carry_o) && $stable(zero_o))); // R10

    AST_SHIFT_FILLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we_o |-> !pair_lo_o[0]); // R6

    AST_ZERO_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_o && zero_o) |-> (pair_lo_o == '0 && pair_hi_o == '0 && !carry_o)); // R8
endmodule

bind fmul_unit fmul_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .mul_en_i (mul_en_i),
    .retire_o (retire_o),
    .pair_we_o(pair_we_o),
    .pair_lo_o(pair_lo_o),
    .pair_hi_o(pair_hi_o),
    .flag_we_o(flag_we_o),
    .carry_o  (carry_o),
    .zero_o   (zero_o)
);

// File: tb/fmul_unit_test.sv
module fmul_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        mul_en_i = 1'b1;
    logic [4:0]  src_a_idx_o, src_b_idx_o;
    logic [7:0]  src_a_data_i, src_b_data_i;
    logic        retire_o, pair_we_o, flag_we_o, carry_o, zero_o;
    logic [7:0]  pair_lo_o, pair_hi_o;

    logic [7:0] rf [32];
    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] e_lo = '0, e_hi = '0;
    logic       e_c = 1'b0, e_z = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    assign src_a_data_i = rf[src_a_idx_o];
    assign src_b_data_i = rf[src_b_idx_o];

    fmul_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .mul_en_i(mul_en_i), .src_a_idx_o(src_a_idx_o), .src_b_idx_o(src_b_idx_o),
        .src_a_data_i(src_a_data_i), .src_b_data_i(src_b_data_i),
        .retire_o(retire_o), .pair_we_o(pair_we_o), .pair_lo_o(pair_lo_o),
        .pair_hi_o(pair_hi_o), .flag_we_o(flag_we_o), .carry_o(carry_o), .zero_o(zero_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // kind: 0 unsigned x unsigned, 1 signed x signed, 2 signed x unsigned
    function automatic logic [15:0] ref_prod(int kind, logic [7:0] a, logic [7:0] b);
        int ia, ib, p;
        ia = (kind == 0) ? int'(a) : int'($signed(a));
        ib = (kind == 1) ? int'($signed(b)) : int'(b);
        p  = ia * ib;
        return p[15:0];
    endfunction

    function automatic logic [15:0] encode(int kind, logic [2:0] d, logic [2:0] s);
        logic b7, b3;
        b7 = (kind != 0);
        b3 = (kind != 1);
        return {8'h03, b7, d, b3, s};
    endfunction

    task automatic run_op(int kind, logic [2:0] d, logic [2:0] s,
                          logic [7:0] a, logic [7:0] b, logic en);
        logic [15:0] p;
        @(negedge clk);
        rf[16 + int'(d)] = a;
        rf[16 + int'(s)] = b;
        instr_i  = encode(kind, d, s);
        mul_en_i = en;
        issue_i  = 1'b1;
        #1;
        chk("R2 src_a_idx", 32'(src_a_idx_o), 32'(16 + int'(d)));
        chk("R2 src_b_idx", 32'(src_b_idx_o), 32'(16 + int'(s)));
        p = ref_prod(kind, rf[16 + int'(d)], rf[16 + int'(s)]);
        if (en) begin
            {e_hi, e_lo} = {p[14:0], 1'b0};
            e_c = p[15];
            e_z = (p == 16'h0);
        end
        @(negedge clk);
        issue_i = 1'b0;
        chk("R9 retire", 32'(retire_o), 32'd1);
        chk(en ? "R9 pair_we" : "R10 pair_we", 32'(pair_we_o), 32'(en));
        chk(en ? "R9 flag_we" : "R10 flag_we", 32'(flag_we_o), 32'(en));
        chk(kind == 0 ? "R3/R6 result" : kind == 1 ? "R4/R6 result" : "R5/R6 result",
            32'({pair_hi_o, pair_lo_o}), 32'({e_hi, e_lo}));
        chk("R7 carry", 32'(carry_o), 32'(e_c));
        chk("R8 zero", 32'(zero_o), 32'(e_z));
        @(negedge clk);
        chk("R9 retire pulse ends", 32'(retire_o), 32'd0);
    endtask

    task automatic run_bad(logic [15:0] w);
        @(negedge clk);
        instr_i  = w;
        mul_en_i = 1'b1;
        issue_i  = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        chk("R1 no retire", 32'(retire_o), 32'd0);
        chk("R1 no write", 32'(pair_we_o), 32'd0);
        chk("R1 pair kept", 32'({pair_hi_o, pair_lo_o}), 32'({e_hi, e_lo}));
        chk("R1 flags kept", 32'({carry_o, zero_o}), 32'({e_c, e_z}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7);
        repeat (3) @(negedge clk);
        chk("R11 reset retire", 32'(retire_o), 32'd0);
        chk("R11 reset outputs", 32'({pair_we_o, flag_we_o, pair_hi_o, pair_lo_o, carry_o, zero_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", 32'(retire_o), 32'd0);

        for (int k = 0; k < 3; k++) begin
            run_op(k, 3'd0, 3'd1, 8'h80, 8'h80, 1'b1);
            run_op(k, 3'd2, 3'd7, 8'hFF, 8'hFF, 1'b1);
            run_op(k, 3'd5, 3'd4, 8'h00, 8'h9C, 1'b1);
            run_op(k, 3'd6, 3'd3, 8'h80, 8'h7F, 1'b1);
            run_op(k, 3'd7, 3'd7, 8'hC3, 8'hC3, 1'b1);
        end

        run_op(2, 3'd1, 3'd2, 8'h12, 8'h34, 1'b0); // R10 disabled
        run_op(1, 3'd3, 3'd4, 8'hFF, 8'hFF, 1'b0); // R10 disabled

        run_bad({8'h03, 1'b0, 3'd1, 1'b0, 3'd2}); // R1 code 2'b00
        run_bad({8'h02, 1'b1, 3'd1, 1'b1, 3'd2}); // R1 wrong major
        run_bad({8'h83, 1'b1, 3'd1, 1'b0, 3'd2}); // R1 wrong major

        for (int i = 0; i < 150; i++) begin
            run_op(int'($urandom_range(0, 2)), 3'($urandom), 3'($urandom),
                   8'($urandom), 8'($urandom), ($urandom_range(0, 9) != 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule